// File: doc/BRIEF.md
# Token-Driven Wavefront Matrix Multiplier

This block multiplies two square unsigned matrices, C = A × B, on an N × N grid of processing elements. No global schedule governs it: each element runs when operands reach it. Each element (i,j) keeps one accumulator. It starts at zero and adds a_ik × b_kj once per wave k, so the product is built as a sum of outer products of column k of A with row k of B.

Operands travel between neighbouring elements through small FIFO link queues. Element (i,j) consumes one A token and one B token in a single step. It hands the A token to its east neighbour and the B token to its south neighbour. Elements on the east and south edges drop the token they would otherwise pass on.

An element steps only when both of its input queues hold a token and both of its downstream queues have room. A nonzero product occupies the element for a fixed multi-cycle latency. A step where either operand is zero skips the multiply and finishes in a single cycle, so the timing of the grid depends on the data.

Once every element has completed N waves, the results leave in row-major order through one valid/ready port. Accepting the final result clears the grid for the next product. Input tokens for the next product may already be waiting in the queues at that point.

Top module: `tokgrid_matmul`

## Requirements
- R1: While rst is high and on the cycle after it falls: res_valid = 0, all_done = 0, every a_in_ready and b_in_ready = 1, all accumulators are zero and all link queues are empty.
- R2: Row port i of the A side takes A[i][0], A[i][1], … A[i][N-1] in that order, on bits [i*DW +: DW] of a_in_data. Column port j of the B side takes B[0][j] … B[N-1][j] in that order, on bits [j*DW +: DW] of b_in_data. The results equal the unsigned product, with each C entry AW bits wide.
- R3: The results do not depend on input stalls on any port or on backpressure on res_ready.
- R4: An input port is ready exactly while its first link queue has room. No link queue is ever pushed while full or popped while empty. With the B side idle, row port 0 accepts exactly QDEPTH tokens and then holds a_in_ready[0] low.
- R5: An element stepping with a zero operand leaves its accumulator unchanged and is free again on the next cycle. A product whose A is all zero delivers its first result sooner than a product with all nonzero operands.
- R6: all_done is high only after every element has completed exactly N waves. No element ever exceeds N waves, and res_valid is never high while all_done is low.
- R7: Results leave in row-major order (index i*N+j). res_last is 1 only on index N*N-1. While res_valid is high and res_ready is low, res_data and res_last hold.
- R8: On the clock edge that accepts the last result, the grid clears. all_done is low on the following cycle, and the next product is unaffected by the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in_valid | input | N | Token valid, one per row of the grid |
| a_in_data | input | N*DW | A operands, one lane per row |
| a_in_ready | output | N | Row queue can accept a token |
| b_in_valid | input | N | Token valid, one per column of the grid |
| b_in_data | input | N*DW | B operands, one lane per column |
| b_in_ready | output | N | Column queue can accept a token |
| res_valid | output | 1 | A result is presented |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | AW | One entry of C |
| res_last | output | 1 | Marks the final entry, index N*N-1 |
| all_done | output | 1 | Every element has finished N waves |

## Verification
Assertions check several properties on every cycle:
- no link queue overflows or underflows;
- no element runs past N waves;
- a zero-operand step leaves the accumulator untouched and the element idle;
- a result is never offered without all_done;
- a stalled result holds steady.

Only the bench's scenarios can show the rest: that the values are the true product under random input stalls and output backpressure, that zero-skipping shortens a whole product, that a queue fills to its depth when one operand stream is missing, and that back-to-back products do not contaminate each other.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic {
    UL_IDLE = 1'b0,
    UL_SEND = 1'b1
  } ul_state_t;

  // width of an index that must span x values, never less than one bit
  function automatic int unsigned idx_w(input int unsigned x);
    return (x > 1) ? $clog2(x) : 1;
  endfunction

endpackage

// File: rtl/tg_fifo.sv
module tg_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          not_empty,
  output logic          not_full
);
  import tg_pkg::*;

  localparam int PW = idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign not_empty = (count != '0);
  assign not_full  = (count != CW'(DEPTH));
  assign head      = mem[rd_ptr];

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> not_full);  // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> not_empty); // R4

endmodule

// File: rtl/tg_pe.sv
module tg_pe #(
  parameter int N          = 3,
  parameter int DW         = 8,
  parameter int AW         = 19,
  parameter int MUL_LAT    = 3,
  parameter bit EAST_EDGE  = 1'b0,
  parameter bit SOUTH_EDGE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          a_ne,
  input  logic [DW-1:0] a_din,
  input  logic          b_ne,
  input  logic [DW-1:0] b_din,
  input  logic          e_space,
  input  logic          s_space,
  output logic          fire,
  output logic [AW-1:0] acc,
  output logic          done
);
  import tg_pkg::*;

  localparam int WW = $clog2(N + 1);
  localparam int LW = idx_w(MUL_LAT);

  logic          busy;
  logic [LW-1:0] lat_cnt;
  logic [WW-1:0] wave;
  logic [DW-1:0] opa, opb;
  logic          zero_op, e_ok, s_ok;

  assign zero_op = (a_din == '0) || (b_din == '0);
  assign e_ok    = EAST_EDGE  ? 1'b1 : e_space;
  assign s_ok    = SOUTH_EDGE ? 1'b1 : s_space;
  assign fire    = !clr && !busy && (wave < WW'(N)) && a_ne && b_ne && e_ok && s_ok;
  assign done    = (wave == WW'(N)) && !busy;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc     <= '0;
      wave    <= '0;
      busy    <= 1'b0;
      lat_cnt <= '0;
      opa     <= '0;
      opb     <= '0;
    end else if (fire) begin
      wave <= wave + 1'b1;
      if (!zero_op) begin
        busy    <= 1'b1;
        opa     <= a_din;
        opb     <= b_din;
        lat_cnt <= LW'(MUL_LAT - 1);
      end
    end else if (busy) begin
      if (lat_cnt == '0) begin
        acc  <= acc + AW'(opa) * AW'(opb);
        busy <= 1'b0;
      end else begin
        lat_cnt <= lat_cnt - 1'b1;
      end
    end
  end

  AST_WAVE_BOUND: assert property (@(posedge clk) disable iff (rst) wave <= WW'(N)); // R6
  AST_ZERO_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    (fire && zero_op) |=> $stable(acc));                               // R5
  AST_ZERO_FREE:  assert property (@(posedge clk) disable iff (rst)
                    (fire && zero_op) |=> !busy);                                      // R5

endmodule

// File: rtl/tg_unload.sv
module tg_unload #(
  parameter int NN = 9,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          all_done,
  input  logic [AW-1:0] acc [NN],
  input  logic          res_ready,
  output logic          res_valid,
  output logic [AW-1:0] res_data,
  output logic          res_last,
  output logic          clr
);
  import tg_pkg::*;

  localparam int IW = idx_w(NN);

  ul_state_t     state;
  logic [IW-1:0] idx, nxt;
  logic          beat;

  assign beat = res_valid && res_ready;
  assign clr  = beat && res_last;
  assign nxt  = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= UL_IDLE;
      idx       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_last  <= 1'b0;
    end else begin
      case (state)
        UL_IDLE: begin
          if (all_done) begin
            state     <= UL_SEND;
            idx       <= '0;
            res_valid <= 1'b1;
            res_data  <= acc[0];
            res_last  <= (NN == 1);
          end
        end
        default: begin
          if (beat) begin
            if (res_last) begin
              state     <= UL_IDLE;
              res_valid <= 1'b0;
              res_last  <= 1'b0;
            end else begin
              idx      <= nxt;
              res_data <= acc[nxt];
              res_last <= (nxt == IW'(NN - 1));
            end
          end
        end
      endcase
    end
  end

  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
                          res_valid |-> all_done);                                    // R6
  AST_HOLD_STALLED:     assert property (@(posedge clk) disable iff (rst)
                          (res_valid && !res_ready) |=>
                          (res_valid && $stable(res_data) && $stable(res_last)));      // R7

endmodule

// File: rtl/tokgrid_matmul.sv
module tokgrid_matmul #(
  parameter int N       = 3,
  parameter int DW      = 8,
  parameter int QDEPTH  = 2,
  parameter int MUL_LAT = 3,
  parameter int AW      = 2 * DW + $clog2(N) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    a_in_valid,
  input  logic [N*DW-1:0] a_in_data,
  output logic [N-1:0]    a_in_ready,
  input  logic [N-1:0]    b_in_valid,
  input  logic [N*DW-1:0] b_in_data,
  output logic [N-1:0]    b_in_ready,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_data,
  output logic            res_last,
  output logic            all_done
);

  localparam int NN = N * N;

  logic          a_push [NN];
  logic [DW-1:0] a_din  [NN];
  logic [DW-1:0] a_head [NN];
  logic          a_ne   [NN];
  logic          a_nf   [NN];
  logic          b_push [NN];
  logic [DW-1:0] b_din  [NN];
  logic [DW-1:0] b_head [NN];
  logic          b_ne   [NN];
  logic          b_nf   [NN];
  logic          pe_fire[NN];
  logic [AW-1:0] pe_acc [NN];
  logic [NN-1:0] pe_done;
  logic          clr;
  logic          all_done_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign a_in_ready[g] = a_nf[g * N];
    assign b_in_ready[g] = b_nf[g];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam int K = i * N + j;
      logic e_space, s_space;

      // A link: west edge from the row port, otherwise from the west element
      if (j == 0) begin : g_a_src
        assign a_push[K] = a_in_valid[i] && a_nf[K];
        assign a_din[K]  = a_in_data[i*DW +: DW];
      end else begin : g_a_src
        assign a_push[K] = pe_fire[K-1];
        assign a_din[K]  = a_head[K-1];
      end

      // B link: north edge from the column port, otherwise from the north element
      if (i == 0) begin : g_b_src
        assign b_push[K] = b_in_valid[j] && b_nf[K];
        assign b_din[K]  = b_in_data[j*DW +: DW];
      end else begin : g_b_src
        assign b_push[K] = pe_fire[K-N];
        assign b_din[K]  = b_head[K-N];
      end

      if (j == N - 1) begin : g_e
        assign e_space = 1'b1;
      end else begin : g_e
        assign e_space = a_nf[K+1];
      end
      if (i == N - 1) begin : g_s
        assign s_space = 1'b1;
      end else begin : g_s
        assign s_space = b_nf[K+N];
      end

      tg_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_aq (
        .clk(clk), .rst(rst), .push(a_push[K]), .push_data(a_din[K]),
        .pop(pe_fire[K]), .head(a_head[K]), .not_empty(a_ne[K]), .not_full(a_nf[K])
      );
      tg_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_bq (
        .clk(clk), .rst(rst), .push(b_push[K]), .push_data(b_din[K]),
        .pop(pe_fire[K]), .head(b_head[K]), .not_empty(b_ne[K]), .not_full(b_nf[K])
      );
      tg_pe #(
        .N(N), .DW(DW), .AW(AW), .MUL_LAT(MUL_LAT),
        .EAST_EDGE(j == N - 1), .SOUTH_EDGE(i == N - 1)
      ) u_pe (
        .clk(clk), .rst(rst), .clr(clr),
        .a_ne(a_ne[K]), .a_din(a_head[K]), .b_ne(b_ne[K]), .b_din(b_head[K]),
        .e_space(e_space), .s_space(s_space),
        .fire(pe_fire[K]), .acc(pe_acc[K]), .done(pe_done[K])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) all_done_q <= 1'b0;
    else     all_done_q <= (&pe_done) && !clr;
  end
  assign all_done = all_done_q;

  tg_unload #(.NN(NN), .AW(AW)) u_unload (
    .clk(clk), .rst(rst), .all_done(all_done_q), .acc(pe_acc),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data),
    .res_last(res_last), .clr(clr)
  );

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst) clr |=> !all_done); // R8

endmodule

// File: tb/tokgrid_matmul_tb.sv
`timescale 1ns/1ps
module tokgrid_matmul_tb;
  localparam int N   = 3;
  localparam int DW  = 8;
  localparam int QD  = 2;
  localparam int LAT = 3;
  localparam int AW  = 2 * DW + $clog2(N) + 1;
  localparam int NN  = N * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    a_in_valid, a_in_ready, b_in_valid, b_in_ready;
  logic [N*DW-1:0] a_in_data, b_in_data;
  logic            res_valid, res_ready, res_last, all_done;
  logic [AW-1:0]   res_data;

  logic          a_v [N];
  logic [DW-1:0] a_d [N];
  logic          b_v [N];
  logic [DW-1:0] b_d [N];

  int ma [N][N];
  int mb [N][N];
  int n_chk = 0;
  int n_bad = 0;
  bit timed_out = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_in_valid[i]          = a_v[i];
      a_in_data[i*DW +: DW]  = a_d[i];
      b_in_valid[i]          = b_v[i];
      b_in_data[i*DW +: DW]  = b_d[i];
    end
  end

  tokgrid_matmul #(.N(N), .DW(DW), .QDEPTH(QD), .MUL_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst),
    .a_in_valid(a_in_valid), .a_in_data(a_in_data), .a_in_ready(a_in_ready),
    .b_in_valid(b_in_valid), .b_in_data(b_in_data), .b_in_ready(b_in_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_last(res_last), .all_done(all_done)
  );

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1'b1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    for (int i = 0; i < N; i++) begin a_v[i] = 0; b_v[i] = 0; a_d[i] = '0; b_d[i] = '0; end
    res_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic feed_a(input int i, input int stall);
    int k = 0;
    while (k < N && !timed_out) begin
      @(posedge clk); #1;
      if ($urandom_range(99) >= stall) begin a_v[i] = 1'b1; a_d[i] = DW'(ma[i][k]); end
      else a_v[i] = 1'b0;
      @(negedge clk);
      if (a_v[i] && a_in_ready[i]) k++;
    end
    @(posedge clk); #1 a_v[i] = 1'b0;
  endtask

  task automatic feed_b(input int j, input int stall);
    int k = 0;
    while (k < N && !timed_out) begin
      @(posedge clk); #1;
      if ($urandom_range(99) >= stall) begin b_v[j] = 1'b1; b_d[j] = DW'(mb[k][j]); end
      else b_v[j] = 1'b0;
      @(negedge clk);
      if (b_v[j] && b_in_ready[j]) k++;
    end
    @(posedge clk); #1 b_v[j] = 1'b0;
  endtask

  // feeds A and B, collects C, returns cycles until the first result appears
  task automatic run_product(input string tag, input int stall, input int bp, output int first_at);
    longint exp_c [NN];
    int idx = 0;
    int cyc = 0;
    first_at = -1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        exp_c[i*N+j] = 0;
        for (int k = 0; k < N; k++) exp_c[i*N+j] += longint'(ma[i][k]) * longint'(mb[k][j]);
      end
    for (int i = 0; i < N; i++) begin
      automatic int ii = i;
      fork
        feed_a(ii, stall);
        feed_b(ii, stall);
      join_none
    end
    while (idx < NN && !timed_out) begin
      @(posedge clk); #1 res_ready = ($urandom_range(99) >= bp);
      @(negedge clk); cyc++;
      if (res_valid) begin
        if (first_at < 0) begin
          first_at = cyc;
          chk("R6 all_done with first result", longint'(all_done), 1);
        end
        if (res_ready) begin
          chk(tag, longint'(res_data), exp_c[idx] & ((64'd1 << AW) - 1));
          chk("R7 res_last position", longint'(res_last), longint'(idx == NN - 1));
          idx++;
        end
      end
    end
    @(posedge clk); #1 res_ready = 1'b0;
    @(negedge clk);
    chk("R8 all_done low after last beat", longint'(all_done), 0);
    wait fork;
  endtask

  task automatic fill_rand(input int zero_pct);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = ($urandom_range(99) < zero_pct) ? 0 : int'($urandom_range(255, 1));
        mb[i][j] = ($urandom_range(99) < zero_pct) ? 0 : int'($urandom_range(255, 1));
      end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 res_valid", longint'(res_valid), 0);
    chk("R1 all_done", longint'(all_done), 0);
    chk("R1 a_in_ready", longint'(a_in_ready), (1 << N) - 1);
    chk("R1 b_in_ready", longint'(b_in_ready), (1 << N) - 1);
  endtask

  task automatic t_plain();
    int f;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = i * N + j + 1;
        mb[i][j] = 255 - 7 * (i + j);
      end
    run_product("R2 product", 0, 0, f);
  endtask

  task automatic t_stalls();
    int f;
    for (int r = 0; r < 3; r++) begin
      fill_rand(0);
      run_product("R3 product under stalls", 35, 45, f);
    end
  endtask

  task automatic t_zero_skip();
    int f_zero, f_dense;
    fill_rand(40);
    run_product("R5 product with zeros", 20, 20, f_zero);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 0; mb[i][j] = 200 + i + j; end
    run_product("R5 all-zero A", 0, 0, f_zero);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 100 + j; mb[i][j] = 200 + i + j; end
    run_product("R5 dense product", 0, 0, f_dense);
    chk("R5 zero skip is faster", longint'(f_zero < f_dense), 1);
  endtask

  task automatic t_back_to_back();
    int f;
    for (int r = 0; r < 2; r++) begin
      fill_rand(10);
      run_product("R8 back-to-back product", 10, 10, f);
    end
  endtask

  task automatic t_queue_fill();
    int taken = 0;
    do_reset();
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1 a_v[0] = 1'b1; a_d[0] = 8'd5;
      @(negedge clk);
      if (a_in_ready[0]) taken++;
    end
    @(posedge clk); #1 a_v[0] = 1'b0;
    @(negedge clk);
    chk("R4 tokens accepted", taken, QD);
    chk("R4 ready low when full", longint'(a_in_ready[0]), 0);
    do_reset();
    @(negedge clk);
    chk("R1 reset empties queue", longint'(a_in_ready[0]), 1);
  endtask

  task automatic t_after_flush();
    int f;
    fill_rand(0);
    run_product("R1 product after reset flush", 15, 15, f);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin a_v[i] = 0; b_v[i] = 0; a_d[i] = '0; b_d[i] = '0; end
    res_ready = 1'b0;
    t_reset();
    t_plain();
    t_stalls();
    t_zero_skip();
    t_back_to_back();
    t_queue_fill();
    t_after_flush();
    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule